// File: doc/BRIEF.md
# Multi-Cycle Asynchronous Static Memory Sequencer

This block connects a clocked requester to a static memory that has no clock of its own. A request is a single-cycle valid/ready transfer carrying an address, write data and a write flag. Each accepted request becomes a fixed-length access of `CYC` clock cycles, phases T1 to T`CYC`. During the access the block drives the memory address, an active-high enable and an active-low write strobe, and it presents the write data. At the close of the final phase it either registers the read data returned by the memory or reports that the write has finished.

The access length is computed at elaboration from three parameters: the clock period, the read access time and the write cycle time. It is the larger of the two times divided by the period, rounded up. With the defaults of 20 ns, 65 ns and 75 ns this gives four cycles. The write strobe is never low in the first or the last phase. The first phase gives address setup before the strobe falls. The last phase gives address and data hold after it rises. A parameter selects whether the memory-side controls come straight from flip-flops or are decoded from the phase counter.

Top module: `async_sram_seq`

## Requirements
- R1: While reset is low and in the first cycle after it ends, `req_ready` is 1, `rsp_valid` is 0, `mem_en` is 0 and `mem_wr_n` is 1.
- R2: An access lasts `CYC` = ceil(max(read time, write cycle time) / clock period) cycles, which is 4 by default. `rsp_valid` is high for exactly one cycle, starting `CYC` cycles after the clock edge that accepted the request.
- R3: `mem_en` is 1 for exactly the `CYC` cycles of an access and 0 otherwise. `mem_addr` shows the accepted address for all of those cycles.
- R4: `mem_wr_n` (0 = write) is low only in phases T2 to T(`CYC`-1) of a write access. It is high in T1 and in the last phase, and it never goes low during a read. Each write gives exactly one low pulse.
- R5: `mem_addr` and `mem_wdata` do not change from the start of T1 until the end of the last phase. This gives setup before the strobe falls and hold after it rises.
- R6: `req_ready` is 1 when the block is idle and in the last phase, and 0 in all other phases. A request offered while `req_ready` is 0 is not taken. It changes neither `mem_addr` nor `mem_wr_n`, and if it is withdrawn before the last phase, no access starts.
- R7: A request offered during the last phase is accepted at the end of that phase. Its T1 follows with no idle cycle, in the same cycle as the previous `rsp_valid`.
- R8: After a read, `rsp_rdata` holds the value on `mem_rdata` at the end of the last phase. After a write, `rsp_valid` still pulses but `rsp_rdata` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data driven to the memory |
| mem_rdata | input | DATA_W | Data returned by the memory |
| mem_en | output | 1 | Memory enable, active high |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest case to create from the ports is a request that arrives in the middle of an access. Reaching it needs a second request offered while the block is busy, once in an early phase and once in the last phase. The bench offers a conflicting write during T2 and withdraws it before the last phase, then reads the address back to show the write never reached the memory. It also offers a request exactly in the last phase to show the back-to-back case. The behavioural memory returns unknown data until 65 ns after the address settles, and it records any change of address or data that falls inside the setup or hold window around the strobe.

// File: rtl/asq_pkg.sv
`timescale 1ns/1ps
package asq_pkg;

   typedef enum logic {
      STROBE_DECODED = 1'b0,
      STROBE_FLOPPED = 1'b1
   } strobe_mode_e;

   function automatic int access_cycles(input int period_ps,
                                        input int t_read_ps,
                                        input int t_wcyc_ps);
      int worst;
      worst = (t_read_ps > t_wcyc_ps) ? t_read_ps : t_wcyc_ps;
      return (worst + period_ps - 1) / period_ps;
   endfunction

endpackage

// File: rtl/asq_phase_timer.sv
`timescale 1ns/1ps
module asq_phase_timer #(
   parameter int CYC       = 4,
   parameter bit LOOKAHEAD = 1'b1,
   localparam int CW       = (CYC > 1) ? $clog2(CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   output logic          busy,
   output logic          last,
   output logic          view_busy,
   output logic [CW-1:0] view_phase
);
   localparam logic [CW-1:0] LAST_PH = CW'(CYC - 1);

   logic          busy_q, busy_d;
   logic [CW-1:0] ph_q, ph_d;

   assign busy = busy_q;
   assign last = busy_q && (ph_q == LAST_PH);

   always_comb begin
      busy_d = busy_q;
      ph_d   = ph_q;
      if (fire) begin
         busy_d = 1'b1;
         ph_d   = '0;
      end else if (last) begin
         busy_d = 1'b0;
         ph_d   = '0;
      end else if (busy_q) begin
         ph_d   = ph_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         ph_q   <= '0;
      end else begin
         busy_q <= busy_d;
         ph_q   <= ph_d;
      end
   end

   generate
      if (LOOKAHEAD) begin : g_next_view
         assign view_busy  = busy_d;
         assign view_phase = ph_d;
      end else begin : g_curr_view
         assign view_busy  = busy_q;
         assign view_phase = ph_q;
      end
   endgenerate

endmodule

// File: rtl/asq_strobe_gen.sv
`timescale 1ns/1ps
module asq_strobe_gen #(
   parameter int CYC       = 4,
   parameter bit LOOKAHEAD = 1'b1,
   localparam int CW       = (CYC > 1) ? $clog2(CYC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          view_busy,
   input  logic [CW-1:0] view_phase,
   input  logic          view_write,
   output logic          mem_en,
   output logic          mem_wr_n
);
   localparam logic [CW-1:0] WIN_LO = CW'(1);
   localparam logic [CW-1:0] WIN_HI = CW'(CYC - 2);

   logic in_win, strobe_on;

   assign in_win    = (view_phase >= WIN_LO) && (view_phase <= WIN_HI);
   assign strobe_on = view_busy && view_write && in_win;

   generate
      if (LOOKAHEAD) begin : g_flopped
         logic en_q, wr_n_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               wr_n_q <= 1'b1;
            end else begin
               en_q   <= view_busy;
               wr_n_q <= !strobe_on;
            end
         end
         assign mem_en   = en_q;
         assign mem_wr_n = wr_n_q;
      end else begin : g_decoded
         assign mem_en   = view_busy;
         assign mem_wr_n = !strobe_on;
      end
   endgenerate

endmodule

// File: rtl/asq_req_latch.sv
`timescale 1ns/1ps
module asq_req_latch #(
   parameter int AW        = 8,
   parameter int DW        = 8,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          last,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          view_write,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);
   logic          wr_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rdata_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         if (last && !wr_q) rdata_q <= mem_rdata;
         if (fire) begin
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
      end
   end

   generate
      if (LOOKAHEAD) begin : g_next_op
         assign view_write = fire ? req_write : wr_q;
      end else begin : g_curr_op
         assign view_write = wr_q;
      end
   endgenerate

   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign rsp_valid = done_q;
   assign rsp_rdata = rdata_q;

endmodule

// File: rtl/async_sram_seq.sv
`timescale 1ns/1ps
module async_sram_seq #(
   parameter int                   ADDR_W      = 8,
   parameter int                   DATA_W      = 8,
   parameter int                   CLK_PS      = 20000,
   parameter int                   T_READ_PS   = 65000,
   parameter int                   T_WCYC_PS   = 75000,
   parameter asq_pkg::strobe_mode_e STROBE_MODE = asq_pkg::STROBE_FLOPPED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_en,
   output logic              mem_wr_n
);
   localparam int CYC       = asq_pkg::access_cycles(CLK_PS, T_READ_PS, T_WCYC_PS);
   localparam int CW        = (CYC > 1) ? $clog2(CYC) : 1;
   localparam bit LOOKAHEAD = (STROBE_MODE == asq_pkg::STROBE_FLOPPED);

   generate
      if (CYC < 4) begin : g_bad_cycles
         $error("access needs at least 4 cycles for setup, strobe and hold phases");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("address and data widths must be positive");
      end
      if (CLK_PS < 1) begin : g_bad_period
         $error("clock period must be positive");
      end
   endgenerate

   logic          busy, last, fire;
   logic          view_busy, view_write;
   logic [CW-1:0] view_phase;

   assign req_ready = !busy || last;
   assign fire      = req_valid && req_ready;

   asq_phase_timer #(.CYC(CYC), .LOOKAHEAD(LOOKAHEAD)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .busy       (busy),
      .last       (last),
      .view_busy  (view_busy),
      .view_phase (view_phase)
   );

   asq_req_latch #(.AW(ADDR_W), .DW(DATA_W), .LOOKAHEAD(LOOKAHEAD)) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .last       (last),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_rdata  (mem_rdata),
      .view_write (view_write),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

   asq_strobe_gen #(.CYC(CYC), .LOOKAHEAD(LOOKAHEAD)) u_strobe (
      .clk        (clk),
      .rst_n      (rst_n),
      .view_busy  (view_busy),
      .view_phase (view_phase),
      .view_write (view_write),
      .mem_en     (mem_en),
      .mem_wr_n   (mem_wr_n)
   );

endmodule

// File: rtl/asq_chk.sv
`timescale 1ns/1ps
module asq_chk #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          mem_en,
   input logic          mem_wr_n,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata
);

   // R4
   strobe_inside_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> mem_en);

   // R4
   strobe_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr_n) |-> mem_en);

   // R5
   bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && $past(mem_en) && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

   // R2
   accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_en && !req_ready));

   // R6
   hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !req_ready) |=> mem_en);

   // R2
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

bind async_sram_seq asq_chk #(.AW(ADDR_W), .DW(DATA_W)) u_asq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_en    (mem_en),
   .mem_wr_n  (mem_wr_n),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/test_async_sram_seq.sv
`timescale 1ns/1ps
module test_async_sram_seq;
   localparam int  CYC    = (75000 + 20000 - 1) / 20000;
   localparam real T_ACC  = 65.0;
   localparam real T_SU   = 5.0;
   localparam real T_HOLD = 5.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0, req_write = 1'b0;
   logic [7:0] req_addr = '0, req_wdata = '0;
   logic       req_ready, rsp_valid, mem_en, mem_wr_n;
   logic [7:0] rsp_rdata, mem_addr, mem_wdata;
   logic [7:0] mem_rdata;

   int checks = 0, fails = 0;
   int viol = 0, wpulses = 0, exp_wpulses = 0;
   logic [7:0] prev_rd = 8'h00;

   always #10 clk = ~clk;

   async_sram_seq i_async_sram_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_en(mem_en),
      .mem_wr_n(mem_wr_n));

   // behavioural memory without a clock
   logic [7:0] arr [256];
   realtime t_addr = 0, t_data = 0, t_rise = -1000;
   bit armed = 0, low_seen = 0;

   always @(mem_addr or posedge mem_en) begin
      t_addr = $realtime;
      if (armed && (mem_wr_n === 1'b0 || ($realtime - t_rise) < T_HOLD)) viol++;
   end
   always @(mem_wdata) begin
      t_data = $realtime;
      if (armed && (mem_wr_n === 1'b0 || ($realtime - t_rise) < T_HOLD)) viol++;
   end
   always @(negedge mem_wr_n) begin
      if (armed) begin
         low_seen = 1;
         if (($realtime - t_addr) < T_SU) viol++;
      end
   end
   always @(posedge mem_wr_n) begin
      if (armed && low_seen) begin
         low_seen = 0;
         wpulses++;
         t_rise = $realtime;
         if (($realtime - t_data) < T_SU) viol++;
         arr[mem_addr] = mem_wdata;
      end
   end
   always #1 begin
      if (mem_en === 1'b1 && mem_wr_n === 1'b1 && ($realtime - t_addr) >= T_ACC)
         mem_rdata = arr[mem_addr];
      else
         mem_rdata = 'x;
   end

   task automatic chk1(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // caller is at a negedge; returns at a negedge one cycle after the done pulse
   task automatic run_access(input logic wr, input logic [7:0] a, input logic [7:0] d,
                             input logic [7:0] exp);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      chk1("R6 ready when idle", req_ready, 1'b1);
      if (wr) exp_wpulses++;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= CYC; k++) begin
         chk1("R3 enable during access", mem_en, 1'b1);
         chk8("R3 address during access", mem_addr, a);
         chk1("R4 strobe phase", mem_wr_n, (wr && k >= 2 && k <= CYC - 1) ? 1'b0 : 1'b1);
         chk1("R6 ready phase", req_ready, (k == CYC) ? 1'b1 : 1'b0);
         chk1("R2 no early done", rsp_valid, 1'b0);
         @(negedge clk);
      end
      chk1("R2 done pulse", rsp_valid, 1'b1);
      chk1("R3 enable off after access", mem_en, 1'b0);
      if (wr) chk8("R8 write keeps read data", rsp_rdata, prev_rd);
      else begin
         chk8("R8 read data", rsp_rdata, exp);
         prev_rd = exp;
      end
      @(negedge clk);
      chk1("R2 done lasts one cycle", rsp_valid, 1'b0);
   endtask

   // {write, addr, wdata, expected read}
   localparam logic [24:0] VEC [10] = '{
      {1'b1, 8'h12, 8'h5A, 8'h00},
      {1'b1, 8'hFF, 8'hC3, 8'h00},
      {1'b1, 8'h33, 8'h44, 8'h00},
      {1'b0, 8'h12, 8'h00, 8'h5A},
      {1'b0, 8'hFF, 8'h00, 8'hC3},
      {1'b1, 8'h00, 8'h01, 8'h00},
      {1'b0, 8'h00, 8'h00, 8'h01},
      {1'b1, 8'h12, 8'hA5, 8'h00},
      {1'b0, 8'h12, 8'h00, 8'hA5},
      {1'b0, 8'h33, 8'h00, 8'h44}
   };

   initial begin
      #(200000 * 20);
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk1("R1 reset ready", req_ready, 1'b1);
      chk1("R1 reset done", rsp_valid, 1'b0);
      chk1("R1 reset enable", mem_en, 1'b0);
      chk1("R1 reset strobe", mem_wr_n, 1'b1);
      rst_n = 1'b1;
      armed = 1;
      @(negedge clk);
      chk1("R1 idle enable after reset", mem_en, 1'b0);
      chk1("R1 idle ready after reset", req_ready, 1'b1);

      for (int i = 0; i < 10; i++)
         run_access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

      // R6: a request offered mid-access is held off and withdrawn
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h33;
      @(negedge clk);                       // T1
      req_valid = 1'b0;
      @(negedge clk);                       // T2
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h33; req_wdata = 8'h77;
      #1;
      chk1("R6 held off in T2", req_ready, 1'b0);
      chk8("R6 address untouched", mem_addr, 8'h33);
      @(negedge clk);                       // T3
      chk1("R6 no strobe from held request", mem_wr_n, 1'b1);
      req_valid = 1'b0;
      @(negedge clk);                       // T4
      @(negedge clk);
      chk1("R6 done of read", rsp_valid, 1'b1);
      chk8("R6 read unaffected", rsp_rdata, 8'h44);
      chk1("R6 no access from withdrawn request", mem_en, 1'b0);
      prev_rd = 8'h44;
      @(negedge clk);
      run_access(1'b0, 8'h33, 8'h00, 8'h44);

      // R7: back-to-back, second request offered in the last phase
      req_valid = 1'b1; req_write = 1'b0; req_addr = 8'hFF;
      @(negedge clk);                       // T1
      req_valid = 1'b0;
      repeat (CYC - 1) @(negedge clk);      // last phase
      chk1("R7 ready in last phase", req_ready, 1'b1);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 8'h99;
      exp_wpulses++;
      @(negedge clk);                       // T1 of second access
      req_valid = 1'b0;
      chk1("R7 first done", rsp_valid, 1'b1);
      chk8("R7 first read data", rsp_rdata, 8'hC3);
      chk1("R7 no idle gap", mem_en, 1'b1);
      chk8("R7 second address", mem_addr, 8'h00);
      chk1("R7 second busy", req_ready, 1'b0);
      @(negedge clk);                       // T2
      chk1("R7 second strobe", mem_wr_n, 1'b0);
      repeat (CYC - 1) @(negedge clk);
      chk1("R7 second done", rsp_valid, 1'b1);
      chk8("R8 write keeps read data", rsp_rdata, 8'hC3);
      prev_rd = 8'hC3;
      @(negedge clk);
      run_access(1'b0, 8'h00, 8'h00, 8'h99);

      chk8("R5 setup and hold violations", 8'(viol), 8'd0);
      chk8("R4 one strobe pulse per write", 8'(wpulses), 8'(exp_wpulses));
      report();
   end
endmodule